// File: doc/BRIEF.md
# Flux Transition Interval Sampler

This block timestamps the flux transitions seen on a disk drive's read-data line against the local sample clock. It produces a stream of bytes. Each byte gives the number of clock ticks since the previous reported event. The low bits hold the tick count. The top bit holds the level of the index-hole sensor at the moment the byte was formed. A consumer drains the stream through a valid/ready byte port, typically into a FIFO that is read out as wider words.

The interval counter never saturates. When a gap reaches the largest count that one byte can hold, the block emits a dedicated marker byte. The count then restarts. A gap of any length, such as a whole revolution, therefore comes out as a chain of markers followed by one ordinary code, and the sum of the chain is exact. Both asynchronous inputs pass through flop synchronisers before use. An enable input starts and stops capture. If the consumer stalls and a byte has to be discarded, a sticky overrun flag reports it.

Top module: `flux_sampler`

## Requirements
- R1: After a synchronous reset, `out_valid` and `overrun` are 0.
- R2: `rdata_in` and `index_in` each pass through two synchroniser flops. A falling edge of `rdata_in` first sampled at clock edge n is reported by a byte that is visible just after edge n+2.
- R3: For a transition byte, `out_data[6:0]` equals the number of enabled clock edges since the previous event, counting the current edge. An event is a transition, a marker, or the start of enable. This value lies between 1 and 126.
- R4: If 126 ticks pass with no falling edge, the block emits the marker code 0x7F in `out_data[6:0]` and restarts the count. A transition that lands on tick 126 is reported as code 126, not as a marker.
- R5: `out_data[7]` equals the synchronised level of `index_in` at the edge where the byte was formed. This holds for both marker and transition bytes.
- R6: Rising edges of `rdata_in` produce no byte.
- R7: While `enable` is low, no new byte is formed and the tick count is held at zero. The first interval after `enable` rises is counted from the first enabled edge.
- R8: If an event occurs while a byte is waiting and `out_ready` is low, the new byte is discarded, the held byte is unchanged, and `overrun` goes to 1. `overrun` stays 1 while `enable` is high and clears on the edge after `enable` is low.
- R9: A byte stays valid and stable until it is accepted with `out_ready`. An accepted byte with no new event in the same cycle leaves `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Capture enable |
| rdata_in | input | 1 | Asynchronous read-data line; a falling edge is a flux transition |
| index_in | input | 1 | Asynchronous index-hole sensor level |
| out_ready | input | 1 | Consumer accepts the byte this cycle |
| out_valid | output | 1 | A byte is waiting on out_data |
| out_data | output | 8 | Bit 7 is the index level, bits 6:0 are the tick count or the 0x7F marker |
| overrun | output | 1 | Sticky flag: a byte was discarded because of back-pressure |

## Verification
The hardest case to reach is the collision at the code boundary: a falling edge that lands exactly on tick 126, where the transition code must win over the marker. The bench reaches it by raising enable at a known edge and placing a one-cycle low pulse so that, after the two synchroniser stages and the edge detector, it lands on that tick. A gap of 300 ticks checks that a chain of markers adds up exactly. The overrun case is forced by holding ready low across two transitions, and its sticky behaviour is then checked until enable drops.

// File: rtl/flux_pkg.sv
package flux_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EDGE = 2'd1,
    EV_MARK = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/flux_sync.sv
module flux_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/flux_interval_timer.sv
module flux_interval_timer
  import flux_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              fall,
  output ev_kind_t          ev_kind,
  output logic [CODE_W-1:0] ev_code
);
  localparam logic [CODE_W-1:0] MAX_TICKS = CODE_W'((1 << CODE_W) - 2);
  localparam logic [CODE_W-1:0] MARKER    = CODE_W'((1 << CODE_W) - 1);

  logic [CODE_W-1:0] ticks_q;
  logic [CODE_W-1:0] ticks_now;

  assign ticks_now = ticks_q + 1'b1;

  always_comb begin
    ev_kind = EV_NONE;
    ev_code = ticks_now;
    if (enable) begin
      if (fall) begin
        ev_kind = EV_EDGE;
      end else if (ticks_now == MAX_TICKS) begin
        ev_kind = EV_MARK;
        ev_code = MARKER;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable)        ticks_q <= '0;
    else if (ev_kind != EV_NONE) ticks_q <= '0;
    else                       ticks_q <= ticks_now;
  end
endmodule

// File: rtl/flux_out_stage.sv
module flux_out_stage
  import flux_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  ev_kind_t          ev_kind,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              index_lvl,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CODE_W:0]   out_data,
  output logic              overrun
);
  logic have_ev;
  logic blocked;

  assign have_ev = (ev_kind != EV_NONE);
  assign blocked = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (have_ev && !blocked) begin
      out_valid <= 1'b1;
      out_data  <= {index_lvl, ev_code};
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable)        overrun <= 1'b0;
    else if (have_ev && blocked) overrun <= 1'b1;
  end
endmodule

// File: rtl/flux_sampler.sv
module flux_sampler
  import flux_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            rdata_in,
  input  logic            index_in,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [CODE_W:0] out_data,
  output logic            overrun
);
  logic [1:0]        sync_q;
  logic              rd_s, idx_s, rd_prev, fall;
  ev_kind_t          ev_kind;
  logic [CODE_W-1:0] ev_code;

  flux_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d({index_in, rdata_in}), .q(sync_q)
  );

  assign rd_s  = sync_q[0];
  assign idx_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) rd_prev <= 1'b0;
    else     rd_prev <= rd_s;
  end

  assign fall = rd_prev && !rd_s;

  flux_interval_timer #(.CODE_W(CODE_W)) timer_i (
    .clk(clk), .rst(rst), .enable(enable), .fall(fall),
    .ev_kind(ev_kind), .ev_code(ev_code)
  );

  flux_out_stage #(.CODE_W(CODE_W)) out_i (
    .clk(clk), .rst(rst), .enable(enable),
    .ev_kind(ev_kind), .ev_code(ev_code), .index_lvl(idx_s),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .overrun(overrun)
  );
endmodule

// File: rtl/flux_sampler_chk.sv
module flux_sampler_chk #(
  parameter int CODE_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            enable,
  input logic            out_ready,
  input logic            out_valid,
  input logic [CODE_W:0] out_data,
  input logic            overrun
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !overrun));

  assert_nonzero_code_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[CODE_W-1:0] != '0));

  assert_no_new_byte_R7: assert property (@(posedge clk) disable iff (rst)
    (!enable && !out_valid) |=> !out_valid);

  assert_sticky_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    (overrun && enable) |=> overrun);

  assert_overrun_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !overrun);

  assert_hold_byte_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind flux_sampler flux_sampler_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .enable(enable), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
);

// File: tb/flux_sampler_tb_top.sv
`timescale 1ns/1ps
module flux_sampler_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       rdata_in = 1'b0;
  logic       index_in = 1'b0;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [7:0] out_data;
  logic       overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flux_sampler dut_i (
    .clk(clk), .rst(rst), .enable(enable), .rdata_in(rdata_in),
    .index_in(index_in), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .overrun(overrun)
  );

  // Behavioural reference: input history and interval arithmetic
  int rd_hist[$];
  int ix_hist[$];
  int m_ticks = 0;
  bit m_valid = 0;
  int m_data = 0;
  bit m_ovr = 0;

  initial begin
    for (int i = 0; i < 4; i++) begin
      rd_hist.push_front(0);
      ix_hist.push_front(0);
    end
  end

  always @(posedge clk) begin
    int code;
    bit ev;
    rd_hist.push_front(rst ? 0 : int'(rdata_in));
    ix_hist.push_front(rst ? 0 : int'(index_in));
    void'(rd_hist.pop_back());
    void'(ix_hist.pop_back());
    if (rst) begin
      m_ticks = 0; m_valid = 0; m_data = 0; m_ovr = 0;
    end else begin
      ev = 0; code = 0;
      if (!enable) begin
        m_ticks = 0;
      end else begin
        m_ticks = m_ticks + 1;
        if (rd_hist[2] == 0 && rd_hist[3] == 1) begin
          ev = 1; code = m_ticks; m_ticks = 0;
        end else if (m_ticks == 126) begin
          ev = 1; code = 127; m_ticks = 0;
        end
      end
      if (ev) begin
        if (m_valid && !out_ready) m_ovr = 1;
        else begin
          m_valid = 1;
          m_data = ix_hist[2] * 128 + code;
        end
      end else if (m_valid && out_ready) begin
        m_valid = 0;
      end
      if (!enable) m_ovr = 0;
    end
  end

  int got[$];
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (out_valid !== m_valid) begin
        errors++;
        $display("FAIL R9 valid: actual %0b expected %0b at %0t", out_valid, m_valid, $time);
      end
      if (m_valid && out_data !== 8'(m_data)) begin
        errors++;
        $display("FAIL R3 data: actual %02h expected %02h at %0t", out_data, 8'(m_data), $time);
      end
      if (overrun !== m_ovr) begin
        errors++;
        $display("FAIL R8 overrun: actual %0b expected %0b at %0t", overrun, m_ovr, $time);
      end
      if (out_valid && out_ready) got.push_back(int'(out_data));
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse();
    rdata_in = 1'b0;
    @(negedge clk);
    rdata_in = 1'b1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 overrun after reset", int'(overrun), 0);
    rst = 1'b0;
    rdata_in = 1'b1;
    wait_n(4);

    // R2: latency of a fresh falling edge
    enable = 1'b1;
    wait_n(2);
    rdata_in = 1'b0;
    @(negedge clk); check("r2_lat1", int'(out_valid), 0);
    rdata_in = 1'b1;
    @(negedge clk); check("r2_lat2", int'(out_valid), 0);
    @(negedge clk); check("r2_lat3", int'(out_valid), 1);
    check("r3_first_code", int'(out_data[6:0]), 5);

    // R3: assorted intervals
    pulse(); wait_n(4);
    pulse(); wait_n(19);
    pulse(); pulse(); pulse();
    wait_n(2);
    pulse(); wait_n(60);

    // R5: index level in bytes
    index_in = 1'b1;
    wait_n(3);
    got.delete();
    pulse(); wait_n(4);
    check("r5_count", got.size(), 1);
    if (got.size() > 0) check("r5_index_bit", got[0] / 128, 1);
    index_in = 1'b0;
    wait_n(3);

    // R4: 300-tick gap gives two markers and code 48
    pulse(); wait_n(5);
    got.delete();
    wait_n(299 - 5);
    pulse(); wait_n(5);
    check("R4 gap bytes", got.size(), 3);
    if (got.size() == 3) begin
      check("R4 marker0", got[0], 127);
      check("R4 marker1", got[1], 127);
      check("R4 tail", got[2], 48);
    end

    // R4: transition exactly on tick 126 wins over marker
    enable = 1'b0; wait_n(3);
    got.delete();
    enable = 1'b1;
    wait_n(123);
    pulse(); wait_n(4);
    check("R4 boundary count", got.size(), 1);
    if (got.size() > 0) check("R4 boundary code", got[0], 126);

    // R6: rising edge alone yields no byte
    rdata_in = 1'b0; wait_n(6);
    got.delete();
    rdata_in = 1'b1; wait_n(6);
    check("R6 no byte on rise", got.size(), 0);

    // R7: disabled transitions ignored
    enable = 1'b0; wait_n(3);
    got.delete();
    pulse(); wait_n(3); pulse(); wait_n(5);
    check("R7 no byte while disabled", got.size(), 0);
    check("R7 valid low while disabled", int'(out_valid), 0);

    // R8: overrun under back-pressure
    enable = 1'b1;
    out_ready = 1'b0;
    pulse(); wait_n(4);
    check("R8 held valid", int'(out_valid), 1);
    pulse(); wait_n(4);
    check("R8 overrun set", int'(overrun), 1);
    out_ready = 1'b1; wait_n(2);
    check("R8 overrun sticky", int'(overrun), 1);
    enable = 1'b0; wait_n(2);
    check("R8 overrun cleared", int'(overrun), 0);
    check("R9 drained", int'(out_valid), 0);

    wait_n(5);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule